// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block sits on the terminal boundary of an embedded core. In functional operation it is transparent: system signals reach the core inputs and the core outputs reach the system. For test it can isolate the core and connect it instead to a narrow test bus. In core-internal test, the test bus drives the core inputs and observes the core outputs. In core-external test, the test bus drives the wrapper's system-facing outputs toward neighbouring logic and observes what arrives on the system-facing inputs. A bypass path carries test bus data through a single register stage without involving the core.

The test bus is `TW` bits wide and the core has `NI` input and `NO` output terminals. Stimulus enters as `TW`-bit slices and is deserialised into a full word. The word is applied to the terminals only when an update strobe is given, so a half-loaded word never reaches the core or its neighbours. Responses are captured as a full word on a capture strobe and then leave as `TW`-bit slices, least significant slice first, with the unused bits of the last slice padded with zero. Stimulus and response shift in the same cycles, as in a scan chain. The mode is held in a register that follows the requested mode only while no shift is in progress.

Top module: `cwrap_core_wrapper`

## Requirements
- R1: In functional mode (mode code 0), `core_in` equals `sys_in`, `sys_out` equals `core_out`, and `tst_do` is zero.
- R2: In internal test mode (mode code 1), `core_in` shows the applied core word and `sys_out` is held at zero whatever `core_out` does.
- R3: In external test mode (mode code 2), `sys_out` shows the applied system word and `core_in` follows `sys_in`.
- R4: In bypass mode (mode code 3), `tst_do` equals the `tst_di` of the previous clock cycle and has no combinational path from `tst_di`. `core_in` follows `sys_in` and `sys_out` follows `core_out`.
- R5: Each shift cycle in a test mode takes one `TW`-bit slice from `tst_di`. Of the last ceil(NI/TW) slices (internal test) or the last ceil(NO/TW) slices (external test), the earliest fills the least significant bits of the word. Bits beyond NI or NO in the last slice are dropped.
- R6: The applied core word changes only when `update_stb` is given in internal test mode, and the applied system word changes only when `update_stb` is given in external test mode. Shifting alone never changes either word, and an update strobe in any other mode is ignored.
- R7: When `capture_stb` is given in internal test mode the wrapper latches `core_out`, and in external test mode it latches `sys_in`. On the next cycle `tst_do` shows bits [TW-1:0] of the latched word. Each further shift presents the next slice, with bits above the word's width reading zero. When capture and shift arrive in the same cycle, capture wins.
- R8: The mode register takes the value of `mode_req` on every clock edge at which `shift_en` is low, and it keeps its value while `shift_en` is high.
- R9: After reset the wrapper is in functional mode and both applied words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode: 0 functional, 1 internal test, 2 external test, 3 bypass |
| shift_en | input | 1 | Shift one slice in and one slice out; freezes the mode register |
| update_stb | input | 1 | Apply the deserialised word to the terminals |
| capture_stb | input | 1 | Latch the response word for shifting out |
| tst_di | input | TW | Test bus data in |
| tst_do | output | TW | Test bus data out |
| sys_in | input | NI | Functional inputs arriving from the system |
| core_in | output | NI | Inputs delivered to the core |
| core_out | input | NO | Outputs produced by the core |
| sys_out | output | NO | Outputs delivered to the system |

## Verification
The bench shifts a full stimulus word and watches `core_in` after every slice, so a wrapper that applied bits before the update strobe would show a half-loaded word. The top input slice carries ones above bit NI, so a wrapper that did not drop the padding, or took the wrong slice offset, would show a corrupted word. On the response side, the bench reads the slices one at a time and also issues capture and shift together, which catches slice reordering, missing zero padding and a shift that overrides capture. It requests a mode change while a shift is in progress, and it gives an update strobe in functional mode. A wrapper that left its mode early would hand `core_in` back to the system at once, and one that honoured the stray strobe would overwrite the applied core word.

// File: rtl/cwrap_pkg.sv
package cwrap_pkg;

  typedef enum logic [1:0] {
    MD_FUNC = 2'd0,
    MD_INT  = 2'd1,
    MD_EXT  = 2'd2,
    MD_BYP  = 2'd3
  } wmode_e;

  function automatic int unsigned slice_cnt(input int unsigned bits, input int unsigned w);
    return (bits + w - 1) / w;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cwrap_rst_sync.sv
module cwrap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/cwrap_mode_ctl.sv
module cwrap_mode_ctl
  import cwrap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       shift_en,
  output wmode_e     mode_q
);
  wmode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (!shift_en) mode_d = wmode_e'(mode_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_FUNC;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/cwrap_deser.sv
module cwrap_deser
  import cwrap_pkg::*;
#(
  parameter int unsigned TW = 4,
  parameter int unsigned NI = 10,
  parameter int unsigned NO = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wmode_e        mode,
  input  logic          shift_en,
  input  logic          update_stb,
  input  logic [TW-1:0] tst_di,
  output logic [NI-1:0] core_word,
  output logic [NO-1:0] sys_word
);
  localparam int unsigned SLI   = slice_cnt(NI, TW);
  localparam int unsigned SLO   = slice_cnt(NO, TW);
  localparam int unsigned SMAX  = max_u(SLI, SLO);
  localparam int unsigned CW    = SMAX * TW;
  localparam int unsigned OFF_I = (SMAX - SLI) * TW;
  localparam int unsigned OFF_O = (SMAX - SLO) * TW;

  logic [CW-1:0] chain_q, chain_d;
  logic [NI-1:0] core_d;
  logic [NO-1:0] sys_d;
  logic          scan_en;
  logic [CW-1:0] shifted;

  assign scan_en = shift_en && ((mode == MD_INT) || (mode == MD_EXT));

  generate
    if (SMAX > 1) begin : g_multi
      assign shifted = {tst_di, chain_q[CW-1:TW]};
    end else begin : g_single
      assign shifted = tst_di;
    end
  endgenerate

  always_comb begin
    chain_d = chain_q;
    if (scan_en) chain_d = shifted;
  end

  always_comb begin
    core_d = core_word;
    sys_d  = sys_word;
    if (update_stb && (mode == MD_INT)) core_d = chain_q[OFF_I +: NI];
    if (update_stb && (mode == MD_EXT)) sys_d  = chain_q[OFF_O +: NO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q   <= '0;
      core_word <= '0;
      sys_word  <= '0;
    end else begin
      chain_q   <= chain_d;
      core_word <= core_d;
      sys_word  <= sys_d;
    end
  end
endmodule

// File: rtl/cwrap_ser.sv
module cwrap_ser
  import cwrap_pkg::*;
#(
  parameter int unsigned TW = 4,
  parameter int unsigned NI = 10,
  parameter int unsigned NO = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wmode_e        mode,
  input  logic          shift_en,
  input  logic          capture_stb,
  input  logic [NO-1:0] core_out,
  input  logic [NI-1:0] sys_in,
  output logic [TW-1:0] slice_out
);
  localparam int unsigned SLI  = slice_cnt(NI, TW);
  localparam int unsigned SLO  = slice_cnt(NO, TW);
  localparam int unsigned SMAX = max_u(SLI, SLO);
  localparam int unsigned CW   = SMAX * TW;

  logic [CW-1:0] resp_q, resp_d, cap_word;
  logic          active;

  assign active = (mode == MD_INT) || (mode == MD_EXT);

  always_comb begin
    cap_word = '0;
    if (mode == MD_INT) cap_word[NO-1:0] = core_out;
    else                cap_word[NI-1:0] = sys_in;
  end

  always_comb begin
    resp_d = resp_q;
    if (active && capture_stb)   resp_d = cap_word;
    else if (active && shift_en) resp_d = resp_q >> TW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_q <= '0;
    else        resp_q <= resp_d;
  end

  assign slice_out = resp_q[TW-1:0];
endmodule

// File: rtl/cwrap_bypass.sv
module cwrap_bypass #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] tst_di,
  output logic [TW-1:0] byp_q
);
  logic [TW-1:0] byp_d;

  always_comb begin
    byp_d = '0;
    if (en) byp_d = tst_di;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= '0;
    else        byp_q <= byp_d;
  end
endmodule

// File: rtl/cwrap_core_wrapper.sv
module cwrap_core_wrapper
  import cwrap_pkg::*;
#(
  parameter int unsigned TW = 4,
  parameter int unsigned NI = 10,
  parameter int unsigned NO = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_req,
  input  logic          shift_en,
  input  logic          update_stb,
  input  logic          capture_stb,
  input  logic [TW-1:0] tst_di,
  output logic [TW-1:0] tst_do,
  input  logic [NI-1:0] sys_in,
  output logic [NI-1:0] core_in,
  input  logic [NO-1:0] core_out,
  output logic [NO-1:0] sys_out
);
  logic          rst_n_s;
  wmode_e        mode_q;
  logic [NI-1:0] core_word;
  logic [NO-1:0] sys_word;
  logic [TW-1:0] resp_slice;
  logic [TW-1:0] byp_q;

  cwrap_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  cwrap_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .mode_req (mode_req),
    .shift_en (shift_en),
    .mode_q   (mode_q)
  );

  cwrap_deser #(.TW(TW), .NI(NI), .NO(NO)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mode       (mode_q),
    .shift_en   (shift_en),
    .update_stb (update_stb),
    .tst_di     (tst_di),
    .core_word  (core_word),
    .sys_word   (sys_word)
  );

  cwrap_ser #(.TW(TW), .NI(NI), .NO(NO)) u_ser (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .mode        (mode_q),
    .shift_en    (shift_en),
    .capture_stb (capture_stb),
    .core_out    (core_out),
    .sys_in      (sys_in),
    .slice_out   (resp_slice)
  );

  cwrap_bypass #(.TW(TW)) u_byp (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .en     (mode_q == MD_BYP),
    .tst_di (tst_di),
    .byp_q  (byp_q)
  );

  always_comb begin
    core_in = sys_in;
    sys_out = core_out;
    tst_do  = '0;
    unique case (mode_q)
      MD_INT: begin
        core_in = core_word;
        sys_out = '0;
        tst_do  = resp_slice;
      end
      MD_EXT: begin
        sys_out = sys_word;
        tst_do  = resp_slice;
      end
      MD_BYP:  tst_do = byp_q;
      default: tst_do = '0;
    endcase
  end
endmodule

// File: rtl/cwrap_core_wrapper_chk.sv
module cwrap_core_wrapper_chk
  import cwrap_pkg::*;
#(
  parameter int unsigned TW = 4,
  parameter int unsigned NI = 10,
  parameter int unsigned NO = 7
) (
  input logic          clk,
  input logic          rst_n,
  input wmode_e        mode_q,
  input logic          shift_en,
  input logic          update_stb,
  input logic          capture_stb,
  input logic [TW-1:0] tst_di,
  input logic [TW-1:0] tst_do,
  input logic [NI-1:0] sys_in,
  input logic [NI-1:0] core_in,
  input logic [NO-1:0] core_out,
  input logic [NO-1:0] sys_out
);
  logic [TW-1:0] co_low;

  always_comb begin
    co_low = '0;
    for (int i = 0; i < int'(TW); i++) begin
      if (i < int'(NO)) co_low[i] = core_out[i];
    end
  end

  a_r1_func_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_FUNC) |-> (core_in == sys_in && sys_out == core_out && tst_do == '0));

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(mode_q));

  a_r4_bypass_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BYP && $past(mode_q) == MD_BYP) |-> (tst_do == $past(tst_di)));

  a_r6_core_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_INT && $past(mode_q) == MD_INT && !$past(update_stb))
      |-> (core_in == $past(core_in)));

  a_r6_sys_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_EXT && $past(mode_q) == MD_EXT && !$past(update_stb))
      |-> (sys_out == $past(sys_out)));

  a_r7_first_slice: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(capture_stb) && $past(mode_q) == MD_INT && mode_q == MD_INT)
      |-> (tst_do == $past(co_low)));

  a_r2_sys_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_INT) |-> (sys_out == '0));
endmodule

bind cwrap_core_wrapper cwrap_core_wrapper_chk #(.TW(TW), .NI(NI), .NO(NO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_q      (mode_q),
  .shift_en    (shift_en),
  .update_stb  (update_stb),
  .capture_stb (capture_stb),
  .tst_di      (tst_di),
  .tst_do      (tst_do),
  .sys_in      (sys_in),
  .core_in     (core_in),
  .core_out    (core_out),
  .sys_out     (sys_out)
);

// File: tb/sim_cwrap_core_wrapper.sv
module sim_cwrap_core_wrapper;
  localparam int TW = 4;
  localparam int NI = 10;
  localparam int NO = 7;

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode_req;
  logic          shift_en, update_stb, capture_stb;
  logic [TW-1:0] tst_di;
  logic [TW-1:0] tst_do;
  logic [NI-1:0] sys_in;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] sys_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cwrap_core_wrapper #(.TW(TW), .NI(NI), .NO(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .shift_en(shift_en),
    .update_stb(update_stb), .capture_stb(capture_stb), .tst_di(tst_di),
    .tst_do(tst_do), .sys_in(sys_in), .core_in(core_in),
    .core_out(core_out), .sys_out(sys_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_req = m;
    shift_en = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode_req = 2'd0; shift_en = 0; update_stb = 0; capture_stb = 0;
    tst_di = '0; sys_in = 10'h2A5; core_out = 7'h33;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R9 reset core_in follows sys_in", 16'(core_in), 16'h2A5);
    chk("R9 reset sys_out follows core_out", 16'(sys_out), 16'h33);
    chk("R9 reset tst_do zero", 16'(tst_do), 16'h0);
  endtask

  task automatic t_normal();
    logic [NI-1:0] si [3] = '{10'h000, 10'h3FF, 10'h155};
    logic [NO-1:0] co [3] = '{7'h7F, 7'h00, 7'h2A};
    for (int k = 0; k < 3; k++) begin
      sys_in = si[k]; core_out = co[k]; tst_di = 4'hF;
      step();
      chk("R1 core_in", 16'(core_in), 16'(si[k]));
      chk("R1 sys_out", 16'(sys_out), 16'(co[k]));
      chk("R1 tst_do", 16'(tst_do), 16'h0);
    end
  endtask

  task automatic t_intest();
    logic [TW-1:0] sl [3] = '{4'hA, 4'h5, 4'hF};
    set_mode(2'd1);
    core_out = 7'h6E; sys_in = 10'h111;
    step();
    chk("R9 applied core word zero", 16'(core_in), 16'h0);
    chk("R2 sys_out held zero", 16'(sys_out), 16'h0);
    for (int k = 0; k < 3; k++) begin
      tst_di = sl[k]; shift_en = 1'b1;
      step();
      chk("R6 no partial word on core_in", 16'(core_in), 16'h0);
    end
    shift_en = 1'b0; update_stb = 1'b1;
    step();
    update_stb = 1'b0;
    chk("R5 deserialised core word", 16'(core_in), 16'h35A);
    sys_in = 10'h0F0;
    step();
    chk("R2 core_in ignores sys_in", 16'(core_in), 16'h35A);
    core_out = 7'h5B; capture_stb = 1'b1;
    step();
    capture_stb = 1'b0;
    chk("R7 first slice", 16'(tst_do), 16'hB);
    tst_di = 4'h0; shift_en = 1'b1;
    step();
    chk("R7 second slice padded", 16'(tst_do), 16'h5);
    step();
    shift_en = 1'b0;
    chk("R7 beyond word reads zero", 16'(tst_do), 16'h0);
    chk("R6 shifting keeps core word", 16'(core_in), 16'h35A);
    core_out = 7'h3C; capture_stb = 1'b1; shift_en = 1'b1;
    step();
    capture_stb = 1'b0; shift_en = 1'b0;
    chk("R7 capture beats shift", 16'(tst_do), 16'hC);
  endtask

  task automatic t_extest();
    set_mode(2'd2);
    sys_in = 10'h2C7;
    step();
    chk("R3 core_in follows sys_in", 16'(core_in), 16'h2C7);
    chk("R9 applied system word zero", 16'(sys_out), 16'h0);
    tst_di = 4'hD; shift_en = 1'b1;
    step();
    tst_di = 4'hC;
    step();
    shift_en = 1'b0;
    chk("R6 sys_out unchanged before update", 16'(sys_out), 16'h0);
    update_stb = 1'b1;
    step();
    update_stb = 1'b0;
    chk("R3 deserialised system word", 16'(sys_out), 16'h4D);
    capture_stb = 1'b1;
    step();
    capture_stb = 1'b0;
    chk("R3 capture sys_in slice 0", 16'(tst_do), 16'h7);
    shift_en = 1'b1;
    step();
    chk("R7 capture sys_in slice 1", 16'(tst_do), 16'hC);
    step();
    shift_en = 1'b0;
    chk("R7 capture sys_in slice 2", 16'(tst_do), 16'h2);
  endtask

  task automatic t_bypass();
    set_mode(2'd3);
    sys_in = 10'h1E1; core_out = 7'h19;
    tst_di = 4'hA;
    step();
    chk("R4 bypass one stage", 16'(tst_do), 16'hA);
    tst_di = 4'h5;
    #1;
    chk("R4 no combinational path", 16'(tst_do), 16'hA);
    step();
    chk("R4 bypass next value", 16'(tst_do), 16'h5);
    chk("R4 core_in functional", 16'(core_in), 16'h1E1);
    chk("R4 sys_out functional", 16'(sys_out), 16'h19);
  endtask

  task automatic t_mode_lock();
    set_mode(2'd1);
    sys_in = 10'h0AA;
    step();
    chk("R8 back in internal test", 16'(core_in), 16'h35A);
    mode_req = 2'd0; shift_en = 1'b1; tst_di = 4'h0;
    step();
    step();
    chk("R8 mode held during shift", 16'(core_in), 16'h35A);
    shift_en = 1'b0;
    step();
    chk("R8 mode follows after shift", 16'(core_in), 16'h0AA);
    update_stb = 1'b1;
    step();
    update_stb = 1'b0;
    set_mode(2'd1);
    chk("R6 update ignored in functional mode", 16'(core_in), 16'h35A);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_intest();
    t_extest();
    t_bypass();
    t_mode_lock();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule